// File: doc/BRIEF.md
# Multi-format audio serial input port

This block receives a stereo audio stream made of a bit clock, a left/right word clock and one serial data line. Every word-clock period holds a 64-bit stereo frame: 32 bit clocks per channel. The block places each channel's sample according to the selected justification format (I2S, left-justified or right-justified) and the selected sample length. It stores each sample as one 32-bit word, so each frame yields two words.

The stored words go into an 8-entry first-word-fall-through queue. The oldest word and its channel tag are always visible at the read side. The whole block runs on the serial bit clock. Samples that arrive while the queue is full are discarded, and this raises a sticky overflow flag.

Top module: `aud_ser_rx`

## Requirements
- R1: The format input `fmt` selects the framing: 0 is I2S, 1 is left-justified, and 2 or 3 is right-justified.
- R2: The length input `wlen` selects the sample length: 0 is 16 bits, 1 is 18, 2 is 20, 3 is 24, and 4 to 7 is 32 bits.
- R3: In I2S the MSB is sampled on the second rising bit-clock edge after the word clock changes, and word clock low means left. For 32-bit samples, the LSB falls on the first edge of the following half-frame. The word for a half-frame is written on the first edge of the next half-frame, but only if that half-frame lasted exactly 32 edges.
- R4: In left-justified mode the MSB is sampled on the edge where the word-clock change is first seen, and word clock high means left. The word is written on the 32nd edge of the half-frame.
- R5: In right-justified mode the LSB is the 32nd bit of the half-frame, and word clock high means left. Bits before the sample window have no effect on the stored word.
- R6: Each stored word holds the sample MSB-aligned in bit 31, with all bits below the sample cleared. `rd_tag` is 0 for a left sample and 1 for a right sample.
- R7: A frame produces two words, one per channel, in the order they arrived.
- R8: The queue holds 8 words. While it is not empty, `rd_valid` is high and `rd_data`/`rd_tag` show the oldest word. `rd_en` removes that word. `rd_en` has no effect while the queue is empty.
- R9: A word that arrives while the queue is full is discarded, the stored words are kept, and `ovf` goes high on the next edge.
- R10: `ovf` stays high until `ovf_clr` is sampled high. If a discard happens on the same edge as a clear, `ovf` stays set.
- R11: After reset the queue is empty and `ovf` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial bit clock; everything samples on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrclk | input | 1 | Left/right word clock |
| sdata | input | 1 | Serial data line |
| fmt | input | 2 | Framing select |
| wlen | input | 3 | Sample length select |
| rd_en | input | 1 | Remove the oldest word |
| ovf_clr | input | 1 | Clear the overflow flag |
| rd_data | output | 32 | Oldest stored word |
| rd_tag | output | 1 | Channel of the oldest word |
| rd_valid | output | 1 | Queue not empty |
| ovf | output | 1 | Sticky overflow flag |

## Verification
Two events can land on the same bit-clock edge: a sample discarded because the queue is full, and the clear request for the overflow flag. The bench provokes this by filling the queue, letting one more word be discarded, and then asserting `ovf_clr` during the final bit of the next half-frame, which is exactly the edge where that word is discarded. It judges the result by reading `ovf`, which must stay high. A later clear with no discard on the same edge must bring the flag low, and the eight words read out afterwards must be the first eight samples sent.

// File: rtl/aud_ser_rx.sv
module aud_ser_rx #(
  parameter int DEPTH = 8,
  parameter int WORD  = 32,
  parameter int HALF  = 32
) (
  input  logic            sclk,
  input  logic            rst_n,
  input  logic            lrclk,
  input  logic            sdata,
  input  logic [1:0]      fmt,
  input  logic [2:0]      wlen,
  input  logic            rd_en,
  input  logic            ovf_clr,
  output logic [WORD-1:0] rd_data,
  output logic            rd_tag,
  output logic            rd_valid,
  output logic            ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(HALF + 2);
  localparam int LW = $clog2(WORD) + 1;

  logic            lr_q;
  logic [CW-1:0]   cnt;
  logic [WORD-2:0] sr;
  logic [LW-1:0]   wl;
  logic [WORD-1:0] win, hi_mask, word;
  logic            is_i2s, is_rj, lr_edge, push, tag, full, pop, wr;

  logic [WORD:0]   mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [AW:0]     lvl;

  assign is_i2s  = (fmt == 2'd0);
  assign is_rj   = fmt[1];
  assign lr_edge = lrclk ^ lr_q;
  assign win     = {sr, sdata};

  always_comb begin
    case (wlen)
      3'd0:    wl = LW'(16);
      3'd1:    wl = LW'(18);
      3'd2:    wl = LW'(20);
      3'd3:    wl = LW'(24);
      default: wl = LW'(WORD);
    endcase
  end

  assign hi_mask = ~({WORD{1'b1}} >> wl);
  assign word    = is_rj ? (win << (LW'(WORD) - wl)) : (win & hi_mask);
  assign tag     = is_i2s ? lr_q : ~lrclk;
  assign push    = is_i2s ? (lr_edge && cnt == CW'(HALF))
                          : (!lr_edge && cnt == CW'(HALF - 1));

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      lr_q <= 1'b0;
      cnt  <= CW'(HALF + 1);
      sr   <= '0;
    end else begin
      lr_q <= lrclk;
      sr   <= win[WORD-2:0];
      if (lr_edge)
        cnt <= CW'(1);
      else if (cnt <= CW'(HALF))
        cnt <= cnt + CW'(1);
    end
  end

  assign full     = (lvl == (AW+1)'(DEPTH));
  assign rd_valid = (lvl != '0);
  assign pop      = rd_en && rd_valid;
  assign wr       = push && (!full || pop);
  assign rd_data  = mem[rp][WORD-1:0];
  assign rd_tag   = mem[rp][WORD];

  always_ff @(posedge sclk) begin
    if (wr) mem[wp] <= {tag, word};
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      lvl <= '0;
      ovf <= 1'b0;
    end else begin
      if (wr)  wp <= wp + AW'(1);
      if (pop) rp <= rp + AW'(1);
      case ({wr, pop})
        2'b10:   lvl <= lvl + (AW+1)'(1);
        2'b01:   lvl <= lvl - (AW+1)'(1);
        default: lvl <= lvl;
      endcase
      if (push && !wr)
        ovf <= 1'b1;
      else if (ovf_clr)
        ovf <= 1'b0;
    end
  end
endmodule

module aud_ser_rx_chk #(
  parameter int DEPTH = 8,
  parameter int AW = 3
) (
  input logic        sclk,
  input logic        rst_n,
  input logic        push,
  input logic        full,
  input logic        rd_en,
  input logic        rd_valid,
  input logic        ovf,
  input logic        ovf_clr,
  input logic [AW:0] lvl
);
  assert_level_bound_R8: assert property (@(posedge sclk) disable iff (!rst_n)
    lvl <= (AW+1)'(DEPTH));

  assert_empty_read_R8: assert property (@(posedge sclk) disable iff (!rst_n)
    (!rd_valid && rd_en && !push) |=> !rd_valid);

  assert_drop_flags_R9: assert property (@(posedge sclk) disable iff (!rst_n)
    (push && full && !rd_en) |=> ovf);

  assert_ovf_sticky_R10: assert property (@(posedge sclk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);

  assert_ovf_rise_R9: assert property (@(posedge sclk) disable iff (!rst_n)
    $rose(ovf) |-> $past(push && full));

  assert_reset_state_R11: assert property (@(posedge sclk)
    !rst_n |-> (!rd_valid && !ovf));
endmodule

bind aud_ser_rx aud_ser_rx_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .sclk(sclk), .rst_n(rst_n), .push(push), .full(full), .rd_en(rd_en),
  .rd_valid(rd_valid), .ovf(ovf), .ovf_clr(ovf_clr), .lvl(lvl)
);

// File: tb/sim_aud_ser_rx.sv
`timescale 1ns/1ps
module sim_aud_ser_rx;
  logic        sclk = 0, rst_n = 0, lrclk = 0, sdata = 0;
  logic [1:0]  fmt = 0;
  logic [2:0]  wlen = 0;
  logic        rd_en = 0, ovf_clr = 0;
  logic [31:0] rd_data;
  logic        rd_tag, rd_valid, ovf;

  int total = 0, bad = 0;
  bit spill_on = 0, spill_b = 0, last_lr = 0, done = 0;

  aud_ser_rx u0 (.sclk(sclk), .rst_n(rst_n), .lrclk(lrclk), .sdata(sdata),
    .fmt(fmt), .wlen(wlen), .rd_en(rd_en), .ovf_clr(ovf_clr),
    .rd_data(rd_data), .rd_tag(rd_tag), .rd_valid(rd_valid), .ovf(ovf));

  always #4 sclk = ~sclk;

  // fmt, wlen, left sample, right sample
  localparam logic [68:0] VEC [8] = '{
    {2'd0, 3'd3, 32'h00ABCDEF, 32'h00123456},
    {2'd0, 3'd4, 32'h80000001, 32'h7FFFFFFE},
    {2'd1, 3'd3, 32'h00C0FFEE, 32'h00800001},
    {2'd1, 3'd4, 32'hDEADBEEF, 32'h01234567},
    {2'd2, 3'd3, 32'h00FEDCBA, 32'h00000001},
    {2'd2, 3'd2, 32'h000ABCDE, 32'h00080000},
    {2'd2, 3'd1, 32'h0002AAAA, 32'h00015555},
    {2'd2, 3'd0, 32'h0000F00D, 32'h00008001}
  };

  function automatic int len_of(input logic [2:0] c);
    case (c)
      3'd0: return 16;
      3'd1: return 18;
      3'd2: return 20;
      3'd3: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] expw(input logic [31:0] s, input int L);
    logic [31:0] m;
    m = (L == 32) ? 32'hFFFFFFFF : ((32'd1 << L) - 32'd1);
    return (s & m) << (32 - L);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; rd_en = 0; ovf_clr = 0; spill_on = 0;
    repeat (2) @(negedge sclk);
    rst_n = 1;
  endtask

  task automatic idle(input bit lr, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge sclk);
      lrclk = lr; sdata = 0; ovf_clr = 0;
    end
  endtask

  // Filler bits are 1 so that stray bits show up in the stored word (R5, R6)
  task automatic send_half(input int f, input int L, input bit lr, input logic [31:0] s, input int clrp);
    for (int p = 0; p < 32; p++) begin
      bit b;
      b = 1'b1;
      if (p == 0 && spill_on) b = spill_b;
      if (f == 0) begin
        if (p >= 1 && p <= L) b = s[L - p];
      end else if (f == 1) begin
        if (p < L) b = s[L - 1 - p];
      end else begin
        if (p >= 32 - L) b = s[31 - p];
      end
      @(negedge sclk);
      lrclk = lr; sdata = b; ovf_clr = (p == clrp);
    end
    spill_on = (f == 0 && L == 32);
    spill_b  = s[0];
    last_lr  = lr;
  endtask

  task automatic tail();
    @(negedge sclk);
    lrclk = ~last_lr; sdata = spill_on ? spill_b : 1'b0; ovf_clr = 0;
    spill_on = 0;
  endtask

  task automatic read_one(input logic [31:0] ed, input bit et, input string req);
    @(negedge sclk);
    chk(rd_valid == 1'b1, {req, " R8 valid"}, 32'(rd_valid), 32'd1);
    chk(rd_data == ed, {req, " R6 data"}, rd_data, ed);
    chk(rd_tag == et, {req, " R6 tag"}, 32'(rd_tag), 32'(et));
    rd_en = 1;
  endtask

  initial begin
    repeat (200000) @(posedge sclk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    do_reset();
    @(negedge sclk);
    chk(rd_valid == 0, "R11 empty", 32'(rd_valid), 0);
    chk(ovf == 0, "R11 ovf", 32'(ovf), 0);

    // R8: reading an empty queue has no effect
    rd_en = 1;
    repeat (3) @(negedge sclk);
    rd_en = 0;
    chk(rd_valid == 0, "R8 empty read", 32'(rd_valid), 0);

    // Vector table walk: R1/R2 encodings, R3 R4 R5 framing, R7 two words per frame
    for (int i = 0; i < 8; i++) begin
      logic [68:0] v;
      int f, L;
      bit left_lr;
      logic [31:0] sl[4];
      string rq;
      v = VEC[i];
      do_reset();
      fmt = v[68:67]; wlen = v[66:64];
      f = int'(fmt); L = len_of(wlen);
      rq = (f == 0) ? "R1/R2 R3" : (f == 1) ? "R1/R2 R4" : "R1/R2 R5";
      left_lr = (f != 0);
      sl[0] = v[63:32]; sl[1] = v[31:0];
      sl[2] = v[63:32] ^ 32'h3C3C96A5; sl[3] = ~v[31:0];
      idle(~left_lr, 3);
      for (int k = 0; k < 4; k++)
        send_half(f, L, (k % 2 == 0) ? left_lr : ~left_lr, sl[k], -1);
      tail();
      for (int k = 0; k < 4; k++)
        read_one(expw(sl[k], L), bit'(k % 2), {rq, " R7"});
      @(negedge sclk);
      rd_en = 0;
      chk(rd_valid == 0, {rq, " R7 count"}, 32'(rd_valid), 0);
    end

    // R8 after empty reads: pointers intact, first frame correct
    do_reset();
    rd_en = 1;
    repeat (2) @(negedge sclk);
    rd_en = 0;
    fmt = 2'd1; wlen = 3'd3;
    idle(1'b0, 3);
    send_half(1, 24, 1'b1, 32'h00112233, -1);
    send_half(1, 24, 1'b0, 32'h00445566, -1);
    tail();
    read_one(32'h11223300, 1'b0, "R8 post-empty");
    read_one(32'h44556600, 1'b1, "R8 post-empty");
    @(negedge sclk);
    rd_en = 0;

    // R9 / R10: overflow, drop, clear colliding with drop, lone clear
    do_reset();
    fmt = 2'd1; wlen = 3'd4;
    idle(1'b0, 3);
    for (int k = 0; k < 8; k++)
      send_half(1, 32, (k % 2 == 0), 32'hA5000000 ^ (32'(k) * 32'h01234567), -1);
    @(negedge sclk);
    chk(ovf == 0, "R9 full no ovf", 32'(ovf), 0);
    send_half(1, 32, 1'b1, 32'hFFFF0000, -1);
    @(negedge sclk);
    chk(ovf == 1, "R9 drop sets ovf", 32'(ovf), 1);
    send_half(1, 32, 1'b0, 32'h0000FFFF, 31);
    @(negedge sclk);
    ovf_clr = 0;
    chk(ovf == 1, "R10 set wins over clear", 32'(ovf), 1);
    @(negedge sclk);
    chk(ovf == 1, "R10 sticky", 32'(ovf), 1);
    ovf_clr = 1;
    @(negedge sclk);
    ovf_clr = 0;
    chk(ovf == 0, "R10 clear", 32'(ovf), 0);
    for (int k = 0; k < 8; k++)
      read_one(32'hA5000000 ^ (32'(k) * 32'h01234567), bit'(k % 2), "R9 kept");
    @(negedge sclk);
    rd_en = 0;
    chk(rd_valid == 0, "R9 dropped words absent", 32'(rd_valid), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule